// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes responses coming back from audio codecs and places them in a circular ring in system memory, where driver software picks them up. Every response becomes an 8-byte entry: the 32-bit response data in the first word and an extended word in the second. The extended word records whether the codec sent the response on its own (unsolicited) and which codec address it came from. The block keeps an 8-bit write pointer and a response counter. It raises a ring status bit when the counter reaches a programmed threshold, or when the command ring has drained, which gives interrupt coalescing.

When software has issued a single command through the immediate path, it sets a busy flag. While that flag is set, the next response goes to an immediate response register and not to the ring. Software registers (ring base, threshold, enables, status clear, pointer reset) reach the block as plain inputs and strobes. Memory writes leave through a simple request/acknowledge port, one 32-bit word at a time. The block stalls the response input while an entry is being written.

Top module: `resp_ring_writer`

## Requirements
- R1: A ring entry goes to index (write pointer + 1) modulo 256, at byte address ring base + 8 × index. The write pointer takes that index only after both words of the entry are acknowledged.
- R2: Each entry is two word writes. The first carries the response data at the entry address. The second goes to entry address + 4 and carries the extended word: bit 4 is 1 for an unsolicited response, bits 3:0 hold the codec address, and all other bits are 0. `memReq` stays high with a stable address until `memAck`, and the second write follows the first acknowledge at once. `rspReady` is low while an entry is in flight.
- R3: A response accepted while ring DMA enable is 0 and the immediate path is not busy is dropped: no memory write, and pointer, counter and status are unchanged.
- R4: A response accepted while `immBusy` is 1 is written to `immResp`. It sets `immValid`, clears `immBusy`, places the codec address on `immCodec`, and makes no ring write. `immBusySet` sets `immBusy`.
- R5: Each completed entry increments the response counter (8 bits, wrapping). If the new count equals the threshold and interrupts are enabled, the ring status bit is set.
- R6: If `cmdRingEmpty` is 1 when an entry completes and interrupts are enabled, the status bit is set. With interrupts disabled, neither condition sets it.
- R7: The status bit stays set until software clears it. A set request in the same cycle wins over a clear. `irqReq` equals status AND interrupt enable.
- R8: A pointer reset strobe clears the write pointer to 0, so the next entry uses index 1. The reset wins over a completing entry in the same cycle.
- R9: A status-clear strobe applied while status is 1 clears the status, zeroes the counter and pulses `fetchKick` for one cycle, one cycle later. Applied while status is 0, it does nothing.
- R10: `immValidClr` clears `immValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | Codec response present |
| rspReady | output | 1 | Block can accept a response |
| rspData | input | DATA_W | Response data |
| rspUnsol | input | 1 | 1 = unsolicited response |
| rspCodec | input | CAD_W | Source codec address |
| memReq | output | 1 | Memory word write request |
| memAddr | output | ADDR_W | Write byte address |
| memData | output | DATA_W | Write data |
| memAck | input | 1 | Current word write done |
| ringBase | input | ADDR_W | Ring base address |
| cntThreshold | input | PTR_W | Coalescing count threshold |
| dmaEn | input | 1 | Ring write enable |
| irqEn | input | 1 | Ring interrupt enable |
| cmdRingEmpty | input | 1 | Command ring has no pending commands |
| wpResetStrobe | input | 1 | Clear write pointer |
| stsClearStrobe | input | 1 | Write-1-to-clear of status bit |
| immBusySet | input | 1 | Software starts an immediate command |
| immValidClr | input | 1 | Software acknowledges immediate response |
| wrPtr | output | PTR_W | Ring write pointer |
| respCount | output | PTR_W | Responses since last status clear |
| ringSts | output | 1 | Ring interrupt status |
| irqReq | output | 1 | Interrupt request |
| fetchKick | output | 1 | One-cycle restart of command fetching |
| immBusy | output | 1 | Immediate command pending |
| immValid | output | 1 | Immediate response held |
| immCodec | output | CAD_W | Codec of immediate response |
| immResp | output | DATA_W | Immediate response data |

## Verification
The bench goes after the pointer wrap from 255 to index 0. A design that does not wrap modulo 256 would write past the ring at base + 2048. It checks that the pointer commits only after the second acknowledge; an early update would show a moved pointer while the extended word is still pending. It sets up the threshold and drain conditions with interrupts both on and off, clears status with and without it being set, and steers a response to the immediate path. These catch a counter that is not zeroed on clear, a kick pulse on a no-op clear, an interrupt raised while disabled, or a busy response that leaks into the ring.

// File: rtl/resp_ring_pkg.sv
package resp_ring_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic loadEntry;   // capture a response as a ring entry
    logic captureImm;  // route response to the immediate register
    logic wordExt;     // second word of the entry is on the bus
    logic advance;     // both words done, commit pointer/counter
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_EXT  = 2'd2
  } ctlState_t;
endpackage

// File: rtl/resp_ring_ctl.sv
module resp_ring_ctl
  import resp_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rspValid,
  input  logic        dmaEn,
  input  logic        immBusy,
  input  logic        memAck,
  output logic        rspReady,
  output logic        memReq,
  output ctlStrobes_t strb
);
  ctlState_t state, stateNext;
  logic accept;

  always_comb begin
    rspReady        = (state == ST_IDLE);
    accept          = rspValid && rspReady;
    memReq          = (state != ST_IDLE);
    strb.captureImm = accept && immBusy;
    strb.loadEntry  = accept && !immBusy && dmaEn;
    strb.wordExt    = (state == ST_EXT);
    strb.advance    = (state == ST_EXT) && memAck;
    stateNext       = state;
    case (state)
      ST_IDLE: if (strb.loadEntry) stateNext = ST_DATA;
      ST_DATA: if (memAck) stateNext = ST_EXT;
      ST_EXT:  if (memAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R2: a request is held until acknowledged, with the same word selected
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(strb.wordExt));
  // R2: the extended word follows the data word without a gap
  assert_ext_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !strb.wordExt && memAck |=> memReq && strb.wordExt);
  // R2: no new response taken while an entry is in flight
  assert_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !rspReady);
endmodule

// File: rtl/resp_ring_dp.sv
module resp_ring_dp
  import resp_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8,
  parameter int CAD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rspUnsol,
  input  logic [CAD_W-1:0]  rspCodec,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [PTR_W-1:0]  cntThreshold,
  input  logic              irqEn,
  input  logic              cmdRingEmpty,
  input  logic              wpResetStrobe,
  input  logic              stsClearStrobe,
  input  logic              immBusySet,
  input  logic              immValidClr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  respCount,
  output logic              ringSts,
  output logic              fetchKick,
  output logic              immBusy,
  output logic              immValid,
  output logic [CAD_W-1:0]  immCodec,
  output logic [DATA_W-1:0] immResp
);
  localparam int ENTRY_SHIFT = 3;                  // 8-byte entries
  localparam int OFF_W       = PTR_W + ENTRY_SHIFT;
  localparam int EXT_PAD     = DATA_W - CAD_W - 1;

  logic [PTR_W-1:0]  entryIdx;
  logic [DATA_W-1:0] entryData;
  logic [DATA_W-1:0] entryExt;
  logic [ADDR_W-1:0] entryAddr;
  logic [PTR_W-1:0]  countBase, countNext;
  logic              stsClearHit, stsSetHit;

  always_comb begin
    entryAddr   = ringBase + {{(ADDR_W-OFF_W){1'b0}}, entryIdx, {ENTRY_SHIFT{1'b0}}};
    memAddr     = strb.wordExt ? entryAddr + ADDR_W'(4) : entryAddr;
    memData     = strb.wordExt ? entryExt : entryData;
    stsClearHit = stsClearStrobe && ringSts;
    countBase   = stsClearHit ? '0 : respCount;
    countNext   = countBase + {{(PTR_W-1){1'b0}}, strb.advance};
    stsSetHit   = strb.advance && irqEn &&
                  ((countNext == cntThreshold) || cmdRingEmpty);
  end

  // Entry capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryIdx  <= '0;
      entryData <= '0;
      entryExt  <= '0;
    end else if (strb.loadEntry) begin
      entryIdx  <= wrPtr + PTR_W'(1);
      entryData <= rspData;
      entryExt  <= {{EXT_PAD{1'b0}}, rspUnsol, rspCodec};
    end
  end

  // Pointer, counter, status and fetch restart
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      respCount <= '0;
      ringSts   <= 1'b0;
      fetchKick <= 1'b0;
    end else begin
      if (wpResetStrobe)     wrPtr <= '0;
      else if (strb.advance) wrPtr <= entryIdx;
      respCount <= countNext;
      if (stsSetHit)           ringSts <= 1'b1;
      else if (stsClearStrobe) ringSts <= 1'b0;
      fetchKick <= stsClearHit;
    end
  end

  // Immediate response path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      immBusy  <= 1'b0;
      immValid <= 1'b0;
      immCodec <= '0;
      immResp  <= '0;
    end else begin
      if (strb.captureImm) begin
        immBusy  <= 1'b0;
        immValid <= 1'b1;
        immCodec <= rspCodec;
        immResp  <= rspData;
      end else begin
        if (immBusySet)  immBusy  <= 1'b1;
        if (immValidClr) immValid <= 1'b0;
      end
    end
  end

  // R1: committing an entry moves the pointer by exactly one
  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !wpResetStrobe |=> wrPtr == $past(wrPtr) + PTR_W'(1));
  // R8: pointer reset takes effect on the next cycle
  assert_ptr_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    wpResetStrobe |=> wrPtr == '0);
  // R7: status stays set without a clear strobe
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    ringSts && !stsClearStrobe |=> ringSts);
  // R9: a kick only follows a clear of a set status
  assert_kick_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchKick) |-> $past(ringSts) && $past(stsClearStrobe));
  // R4: immediate capture leaves valid set and busy cleared
  assert_imm_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureImm |=> immValid && !immBusy);
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import resp_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8,
  parameter int CAD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rspUnsol,
  input  logic [CAD_W-1:0]  rspCodec,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [PTR_W-1:0]  cntThreshold,
  input  logic              dmaEn,
  input  logic              irqEn,
  input  logic              cmdRingEmpty,
  input  logic              wpResetStrobe,
  input  logic              stsClearStrobe,
  input  logic              immBusySet,
  input  logic              immValidClr,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  respCount,
  output logic              ringSts,
  output logic              irqReq,
  output logic              fetchKick,
  output logic              immBusy,
  output logic              immValid,
  output logic [CAD_W-1:0]  immCodec,
  output logic [DATA_W-1:0] immResp
);
  ctlStrobes_t strb;

  resp_ring_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .rspValid (rspValid),
    .dmaEn    (dmaEn),
    .immBusy  (immBusy),
    .memAck   (memAck),
    .rspReady (rspReady),
    .memReq   (memReq),
    .strb     (strb)
  );

  resp_ring_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W),
    .CAD_W  (CAD_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .rspData        (rspData),
    .rspUnsol       (rspUnsol),
    .rspCodec       (rspCodec),
    .ringBase       (ringBase),
    .cntThreshold   (cntThreshold),
    .irqEn          (irqEn),
    .cmdRingEmpty   (cmdRingEmpty),
    .wpResetStrobe  (wpResetStrobe),
    .stsClearStrobe (stsClearStrobe),
    .immBusySet     (immBusySet),
    .immValidClr    (immValidClr),
    .memAddr        (memAddr),
    .memData        (memData),
    .wrPtr          (wrPtr),
    .respCount      (respCount),
    .ringSts        (ringSts),
    .fetchKick      (fetchKick),
    .immBusy        (immBusy),
    .immValid       (immValid),
    .immCodec       (immCodec),
    .immResp        (immResp)
  );

  assign irqReq = ringSts && irqEn;

  // R3: with DMA off and no immediate pending, nothing reaches memory
  assert_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady && !dmaEn && !immBusy |=> !memReq);
  // R4: immediate responses never start a ring write
  assert_imm_no_ring_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady && immBusy |=> !memReq);
endmodule

// File: tb/resp_ring_writer_test.sv
module resp_ring_writer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rspValid = 1'b0, rspUnsol = 1'b0;
  logic [31:0] rspData = '0;
  logic [3:0]  rspCodec = '0;
  logic        memAck = 1'b0;
  logic [31:0] ringBase = 32'h0000_1000;
  logic [7:0]  cntThreshold = 8'd200;
  logic        dmaEn = 1'b1, irqEn = 1'b1, cmdRingEmpty = 1'b0;
  logic        wpResetStrobe = 1'b0, stsClearStrobe = 1'b0;
  logic        immBusySet = 1'b0, immValidClr = 1'b0;
  logic        rspReady, memReq, ringSts, irqReq, fetchKick, immBusy, immValid;
  logic [31:0] memAddr, memData, immResp;
  logic [7:0]  wrPtr, respCount;
  logic [3:0]  immCodec;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] expPtr = '0;
  logic [7:0] expCount = '0;
  logic       expSts = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_ring_writer uut (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .rspUnsol(rspUnsol), .rspCodec(rspCodec),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .memAck(memAck),
    .ringBase(ringBase), .cntThreshold(cntThreshold), .dmaEn(dmaEn),
    .irqEn(irqEn), .cmdRingEmpty(cmdRingEmpty), .wpResetStrobe(wpResetStrobe),
    .stsClearStrobe(stsClearStrobe), .immBusySet(immBusySet),
    .immValidClr(immValidClr), .wrPtr(wrPtr), .respCount(respCount),
    .ringSts(ringSts), .irqReq(irqReq), .fetchKick(fetchKick),
    .immBusy(immBusy), .immValid(immValid), .immCodec(immCodec),
    .immResp(immResp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One full ring entry with a bus-level check of both words (R1, R2, R5, R6)
  task automatic sendRing(input logic [31:0] d, input logic u, input logic [3:0] c);
    logic [7:0]  idx;
    logic [31:0] addr;
    idx  = expPtr + 8'd1;
    addr = ringBase + {21'd0, idx, 3'b000};
    rspData = d; rspUnsol = u; rspCodec = c; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    chk("R2 data req", {31'd0, memReq}, 32'd1);
    chk("R2 ready low", {31'd0, rspReady}, 32'd0);
    chk("R1 data addr", memAddr, addr);
    chk("R2 data word", memData, d);
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    chk("R2 ext req", {31'd0, memReq}, 32'd1);
    chk("R2 ext addr", memAddr, addr + 32'd4);
    chk("R2 ext word", memData, {27'd0, u, c});
    chk("R1 ptr held before ack", {24'd0, wrPtr}, {24'd0, expPtr});
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    expPtr   = idx;
    expCount = expCount + 8'd1;
    if (irqEn && ((expCount == cntThreshold) || cmdRingEmpty)) expSts = 1'b1;
    chk("R1 ptr commit", {24'd0, wrPtr}, {24'd0, expPtr});
    chk("R5 count", {24'd0, respCount}, {24'd0, expCount});
    chk("R5/R6 status", {31'd0, ringSts}, {31'd0, expSts});
    chk("R7 irq", {31'd0, irqReq}, {31'd0, expSts & irqEn});
    chk("R2 idle", {31'd0, memReq}, 32'd0);
  endtask

  task automatic clearSts();
    logic wasSet;
    wasSet = ringSts;
    stsClearStrobe = 1'b1;
    @(negedge clk);
    stsClearStrobe = 1'b0;
    chk("R9 status cleared", {31'd0, ringSts}, 32'd0);
    if (wasSet) expCount = 8'd0;
    expSts = 1'b0;
    chk("R9 count", {24'd0, respCount}, {24'd0, expCount});
    chk("R9 kick", {31'd0, fetchKick}, {31'd0, wasSet});
    @(negedge clk);
    chk("R9 kick one cycle", {31'd0, fetchKick}, 32'd0);
  endtask

  task automatic testReset();
    chk("reset ptr", {24'd0, wrPtr}, 32'd0);
    chk("reset count", {24'd0, respCount}, 32'd0);
    chk("reset sts", {31'd0, ringSts}, 32'd0);
    chk("reset req", {31'd0, memReq}, 32'd0);
    chk("reset ready", {31'd0, rspReady}, 32'd1);
    chk("reset imm", {30'd0, immBusy, immValid}, 32'd0);
  endtask

  task automatic testBasic();
    sendRing(32'hDEAD_BEEF, 1'b0, 4'h3);
    sendRing(32'h1234_5678, 1'b1, 4'hA);
  endtask

  task automatic testDrop();  // R3
    dmaEn = 1'b0;
    rspData = 32'hBAD0_0001; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R3 no write", {31'd0, memReq}, 32'd0);
      @(negedge clk);
    end
    chk("R3 ptr kept", {24'd0, wrPtr}, {24'd0, expPtr});
    chk("R3 count kept", {24'd0, respCount}, {24'd0, expCount});
    chk("R3 sts kept", {31'd0, ringSts}, 32'd0);
    dmaEn = 1'b1;
  endtask

  task automatic testImmediate();  // R4, R10
    immBusySet = 1'b1;
    @(negedge clk);
    immBusySet = 1'b0;
    chk("R4 busy set", {31'd0, immBusy}, 32'd1);
    rspData = 32'hCAFE_0042; rspCodec = 4'h5; rspUnsol = 1'b0; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    chk("R4 imm data", immResp, 32'hCAFE_0042);
    chk("R4 imm codec", {28'd0, immCodec}, 32'd5);
    chk("R4 valid/busy", {30'd0, immValid, immBusy}, 32'd2);
    chk("R4 no ring write", {31'd0, memReq}, 32'd0);
    @(negedge clk);
    chk("R4 ptr kept", {24'd0, wrPtr}, {24'd0, expPtr});
    immValidClr = 1'b1;
    @(negedge clk);
    immValidClr = 1'b0;
    chk("R10 valid cleared", {31'd0, immValid}, 32'd0);
  endtask

  task automatic testThreshold();  // R5, R7, R9
    cntThreshold = expCount + 8'd1;
    sendRing(32'h0000_0011, 1'b0, 4'h1);
    chk("R5 threshold sets", {31'd0, ringSts}, 32'd1);
    sendRing(32'h0000_0022, 1'b0, 4'h1);
    chk("R7 sticky", {31'd0, ringSts}, 32'd1);
    irqEn = 1'b0;
    @(negedge clk);
    chk("R7 irq gated", {31'd0, irqReq}, 32'd0);
    irqEn = 1'b1;
    clearSts();
    clearSts();  // no-op clear: no kick
    cntThreshold = 8'd200;
  endtask

  task automatic testDrain();  // R6
    cmdRingEmpty = 1'b1;
    irqEn = 1'b0;
    sendRing(32'h0000_0033, 1'b1, 4'hF);
    chk("R6 disabled no sts", {31'd0, ringSts}, 32'd0);
    irqEn = 1'b1;
    sendRing(32'h0000_0044, 1'b0, 4'h0);
    chk("R6 drain sets", {31'd0, ringSts}, 32'd1);
    cmdRingEmpty = 1'b0;
    clearSts();
  endtask

  task automatic testWrap();  // R8, R1
    wpResetStrobe = 1'b1;
    @(negedge clk);
    wpResetStrobe = 1'b0;
    expPtr = 8'd0;
    chk("R8 ptr reset", {24'd0, wrPtr}, 32'd0);
    irqEn = 1'b0;
    for (int i = 0; i < 256; i++) sendRing(32'h5000_0000 + i, i[0], i[3:0]);
    chk("R1 wrap to zero", {24'd0, wrPtr}, 32'd0);
    irqEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testDrop();
    testImmediate();
    testThreshold();
    testDrain();
    testWrap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule